// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake lines (clear to send, data set ready, ring indicator and carrier detect) and presents them to a host as one 8-bit status word. The upper nibble shows the present, active-high state of each line. The lower nibble holds four sticky change flags, which record line activity since the host last looked.

Each line is first resynchronised to the block clock. Changes are then detected on the synchronised copy. Three of the lines flag any transition. The ring indicator flags only the end of a ring, which is its inactive-going edge.

A read strobe from the host clears the change flags. A change that arrives in the same cycle as the read is kept and not lost. An interrupt request stays high while any change flag is set.

Top module: `mdm_status_det`

## Requirements
- R1: Status bit 0 becomes 1 when the synchronised `cts_n` changes in either direction, and stays 1 until a read.
- R2: Status bit 1 becomes 1 when the synchronised `dsr_n` changes in either direction, and stays 1 until a read.
- R3: Status bit 2 becomes 1 only when the synchronised `ri_n` goes from 0 to 1. A 1-to-0 transition leaves it unchanged.
- R4: Status bit 3 becomes 1 when the synchronised `dcd_n` changes in either direction, and stays 1 until a read.
- R5: A cycle with `rd_stb` high and no new line change clears status bits 3..0 to 0 on the next clock edge.
- R6: `irq_q` is 1 exactly when at least one of status bits 3..0 is 1, in the same cycle.
- R7: Status bits 4, 5, 6 and 7 equal the inverse of the synchronised `cts_n`, `dsr_n`, `ri_n` and `dcd_n`, in that order. An asserted (low) line therefore reads as 1.
- R8: If a line change is detected in the same cycle as `rd_stb`, that line's change bit reads 1 afterwards. Other change bits are still cleared.
- R9: A line change at the inputs first appears on `status_q` and `irq_q` after the third rising clock edge, through two synchroniser flops and one level register.
- R10: After reset with all lines high, `status_q` is 8'h00 and `irq_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready line, active low, asynchronous |
| ri_n | input | 1 | Ring indicator line, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect line, active low, asynchronous |
| rd_stb | input | 1 | One-cycle host read of the status word |
| status_q | output | 8 | Line states in bits 7..4, change flags in bits 3..0 |
| irq_q | output | 1 | Modem status interrupt request |

## Verification
The bench targets the ring indicator's one-sided edge. A design that flags both edges would raise bit 2 when ring starts and would fail that vector.

It also issues a read in exactly the cycle a new change is detected. A design that lets the clear win would drop that event, and a design that skips the clear would leave an old flag standing.

The bench checks that flags build up across several lines without a read between them. It also checks the output one edge before the expected latency, so a synchroniser that is one stage short or one stage long is caught. Finally, it checks that the state nibble tracks inverted levels rather than raw pins.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  // line index within the packed line vector
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  // lines whose change flag fires only on a 0->1 transition
  localparam logic [NLINES-1:0] RISE_ONLY_MASK = 4'b0100;
  localparam int STW = 2 * NLINES;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= {WIDTH{RST_VAL}};
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RISE_ONLY = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_s,
  input  logic             clr,
  output logic [WIDTH-1:0] level_q,
  output logic [WIDTH-1:0] evt,
  output logic [WIDTH-1:0] flag_q,
  output logic [WIDTH-1:0] flag_nxt
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      if (RISE_ONLY[g]) begin : g_rise
        assign evt[g] = line_s[g] & ~level_q[g];
      end else begin : g_any
        assign evt[g] = line_s[g] ^ level_q[g];
      end
    end
  endgenerate

  // a fresh event wins over a simultaneous clear
  assign flag_nxt = (flag_q & ~{WIDTH{clr}}) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '1;
      flag_q  <= '0;
    end else begin
      level_q <= line_s;
      flag_q  <= flag_nxt;
    end
  end
endmodule

// File: rtl/mdm_status_det.sv
module mdm_status_det
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cts_n,
  input  logic           dsr_n,
  input  logic           ri_n,
  input  logic           dcd_n,
  input  logic           rd_stb,
  output logic [STW-1:0] status_q,
  output logic           irq_q
);
  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] sync_lines;
  logic [NLINES-1:0] level_q;
  logic [NLINES-1:0] edge_evt;
  logic [NLINES-1:0] flag_q;
  logic [NLINES-1:0] flag_nxt;

  assign raw_lines[L_CTS] = cts_n;
  assign raw_lines[L_DSR] = dsr_n;
  assign raw_lines[L_RI]  = ri_n;
  assign raw_lines[L_DCD] = dcd_n;

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_lines),
    .dout(sync_lines)
  );

  mdm_delta #(.WIDTH(NLINES), .RISE_ONLY(RISE_ONLY_MASK)) u_delta (
    .clk     (clk),
    .rst     (rst),
    .line_s  (sync_lines),
    .clr     (rd_stb),
    .level_q (level_q),
    .evt     (edge_evt),
    .flag_q  (flag_q),
    .flag_nxt(flag_nxt)
  );

  assign status_q = {~level_q, flag_q};

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |flag_nxt;
  end
endmodule

// File: rtl/mdm_status_det_chk.sv
module mdm_status_det_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_stb,
  input logic [7:0] status_q,
  input logic       irq_q,
  input logic [3:0] edge_evt
);
  // R1
  cts_delta_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_q[4]) |-> status_q[0]);
  // R2
  dsr_delta_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_q[5]) |-> status_q[1]);
  // R3
  ri_trail_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[2]) |-> $fell(status_q[6]));
  // R4
  dcd_delta_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_q[7]) |-> status_q[3]);
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && edge_evt == 4'b0) |=> status_q[3:0] == 4'b0);
  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|status_q[3:0]));
  // R8
  coincide_keep_chk: assert property (@(posedge clk) disable iff (rst)
    edge_evt[0] |=> status_q[0]);
  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && !rd_stb) |=> status_q[0]);
endmodule

bind mdm_status_det mdm_status_det_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_stb  (rd_stb),
  .status_q(status_q),
  .irq_q   (irq_q),
  .edge_evt(edge_evt)
);

// File: tb/mdm_status_det_test.sv
module mdm_status_det_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 7;
  // vector: {dcd_n, ri_n, dsr_n, cts_n}[12:9], read-after[8], expected status[7:0]
  localparam logic [12:0] VEC [NVEC] = '{
    {4'b1110, 1'b1, 8'h11},  // R1 cts asserts
    {4'b1100, 1'b1, 8'h32},  // R2 dsr asserts
    {4'b1000, 1'b0, 8'h70},  // R3 ring starts: no flag
    {4'b1100, 1'b1, 8'h34},  // R3 ring ends: flag
    {4'b0101, 1'b0, 8'hA9},  // R4 dcd asserts, R1 cts releases
    {4'b0100, 1'b1, 8'hB9},  // R1 sticky accumulate
    {4'b1111, 1'b1, 8'h0B}   // R1 R2 R4 all release
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1, rd_stb = 1'b0;
  logic [7:0] status_q;
  logic irq_q;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_status_det uut (
    .clk(clk), .rst(rst), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .rd_stb(rd_stb), .status_q(status_q), .irq_q(irq_q)
  );

  task automatic chk(input string req, input logic [7:0] exp_st);
    logic exp_irq;
    exp_irq = |exp_st[3:0];
    checks++;
    if (status_q !== exp_st || irq_q !== exp_irq) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               req, status_q, irq_q, exp_st, exp_irq);
    end
  endtask

  task automatic set_lines(input logic [3:0] l);
    {dcd_n, ri_n, dsr_n, cts_n} = l;
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      set_lines(VEC[i][12:9]);
      repeat (3) @(negedge clk);
      chk("R1-R4/R7 vector", VEC[i][7:0]);
      if (VEC[i][8]) begin
        do_read();
        chk("R5", {VEC[i][7:4], 4'h0});
      end
    end

    // R9: latency of exactly three edges
    set_lines(4'b0111);
    repeat (2) @(negedge clk);
    chk("R9 early", 8'h00);
    @(negedge clk);
    chk("R9 R4", 8'h88);
    do_read();
    chk("R5", 8'h80);

    // R8: dsr flag pending, cts change detected in the read cycle
    set_lines(4'b0101);
    repeat (3) @(negedge clk);
    chk("R2", 8'hA2);
    set_lines(4'b0100);
    repeat (2) @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R8", 8'hB1);
    do_read();
    chk("R5", 8'hB0);

    // R10: reset again with lines idle
    set_lines(4'b1111);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule